// File: doc/BRIEF.md
# Per-Source Configurable Interrupt Controller

This block collects up to 64 interrupt inputs and merges them into one interrupt request line for a processor. Each input has its own configuration byte that turns it on or off and picks how it fires: while the input is high, on a rising transition, or on a falling transition. Edge events are caught in status bits. Software clears them by writing ones. Level-mode status bits simply mirror the sampled input.

Software reaches the block over a plain 32-bit register bus, with byte enables and a combinational read path. A read-only register reports the most urgent pending source. By default the lowest-numbered source wins. When rotation is switched on in the global control register, each report of a source moves the start of the search to the next source. This spreads service fairly among inputs that stay active.

All inputs are sampled on every clock. Status bits therefore change on the first clock edge after an input moves. The interrupt line and the reported source follow from the registered state with no further delay.

Top module: `irq_ctrl`

## Requirements
- R1: Source n has a configuration byte at byte address 0x40 + n. The byte is reached through the 32-bit word at 0x40 + 4*(n/4), in byte lane n mod 4. Bit 3 enables the source. Bits [5:4] select the trigger: 0 = level high, 1 = rising edge, 2 = falling edge, 3 = treated as level high. All other bits read back as 0.
- R2: `irq_o` is high exactly when at least one enabled source has its status bit set. A source whose enable bit is 0 never raises `irq_o`.
- R3: In an edge mode, the status bit is set at the first clock edge at which the input differs from its previous sample in the selected direction. This happens even while the source is disabled. A transition in the other direction sets nothing.
- R4: The status bits of sources 0 to 31 sit at bits 0 to 31 of word 0x80. Those of sources 32 to 63 sit at bits 0 to 31 of word 0x84. Writing a 1 to the status bit of an edge-mode source clears it. Writing a 0 leaves it unchanged.
- R5: In level mode, the status bit equals the input as sampled at the previous clock edge, and writes to it have no effect.
- R6: Word 0x88 is read-only. Bit 31 is a valid flag that equals `irq_o`. Bits [5:0] hold the number of the selected pending source. The word reads 0 when nothing is pending.
- R7: With bit 6 of word 0x20 clear, the selected source is the lowest-numbered enabled source with its status bit set.
- R8: With bit 6 of word 0x20 set, a read of 0x88 that returns valid moves the search start to the source after the one reported, wrapping from 63 to 0. The next selection is the first pending source at or after that start. Bit 6 of 0x20 reads back as written.
- R9: After reset all configuration bytes, all status bits, the rotation bit and the search start are 0, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt source inputs |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (advances rotation on 0x88) |
| bus_addr_i | input | 8 | Byte address of a 32-bit word |
| bus_wdata_i | input | 32 | Write data |
| bus_be_i | input | 4 | Byte enables for writes |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Merged interrupt request |

## Verification
Every one of the 64 sources is taken through each trigger mode in turn. The bench probes the cases that separate the modes. It raises an input under a falling-edge setting, where a design with the edge directions swapped would latch it. It holds an edge input high after a write-one clear, where a design that mistakes level for edge would re-assert the interrupt. It writes zero and one to level status bits, which a design that lets clears through would drop. It latches an edge while the source is masked, which a design that gates detection with the enable would lose. Selection is checked on sparse patterns that include sources 0 and 63 and that span the two status words. In rotating mode the bench reads repeatedly so that the search wraps around the end. A fixed-priority design would report the same source again, and an off-by-one pointer would skip or repeat a neighbour.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    TRIG_LEVEL     = 2'd0,
    TRIG_RISE      = 2'd1,
    TRIG_FALL      = 2'd2,
    TRIG_LEVEL_ALT = 2'd3
  } trig_e;

  localparam logic [7:0] A_GCTL    = 8'h20;
  localparam logic [7:0] A_STAT_LO = 8'h80;
  localparam logic [7:0] A_STAT_HI = 8'h84;
  localparam logic [7:0] A_CUR     = 8'h88;

  localparam int CFG_EN_BIT   = 3;
  localparam int CFG_TRIG_LSB = 4;
  localparam int GCTL_ROT_BIT = 6;
  localparam int CUR_VLD_BIT  = 31;

endpackage

// File: rtl/irqc_src_cell.sv
module irqc_src_cell
  import irqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_i,
  input  logic       cfg_we_i,
  input  logic       cfg_en_i,
  input  logic [1:0] cfg_trig_i,
  input  logic       clr_i,
  output logic       en_o,
  output trig_e      trig_o,
  output logic       sta_o,
  output logic       pend_o
);

  logic  en_q, en_d;
  trig_e trig_q, trig_d;
  logic  smp_q;
  logic  sta_q, sta_d;
  logic  hit;
  logic  edge_mode;

  // configuration next state, enabled by the byte write strobe
  always_comb begin
    en_d   = en_q;
    trig_d = trig_q;
    if (cfg_we_i) begin
      en_d   = cfg_en_i;
      trig_d = trig_e'(cfg_trig_i);
    end
  end

  // status next state
  always_comb begin
    edge_mode = (trig_q == TRIG_RISE) || (trig_q == TRIG_FALL);
    case (trig_q)
      TRIG_RISE: hit = src_i & ~smp_q;
      TRIG_FALL: hit = ~src_i & smp_q;
      default:   hit = 1'b0;
    endcase
    if (edge_mode) sta_d = hit | (sta_q & ~clr_i);
    else           sta_d = src_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      trig_q <= TRIG_LEVEL;
      smp_q  <= 1'b0;
      sta_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      trig_q <= trig_d;
      smp_q  <= src_i;
      sta_q  <= sta_d;
    end
  end

  assign en_o   = en_q;
  assign trig_o = trig_q;
  assign sta_o  = sta_q;
  assign pend_o = en_q & sta_q;

  // R3: a selected transition is latched one edge later
  a_r3_rise_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q == TRIG_RISE && src_i && !smp_q) |=> sta_q);
  a_r3_fall_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q == TRIG_FALL && !src_i && smp_q) |=> sta_q);
  // R4: write-one clear without a new edge empties the bit
  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q == TRIG_RISE && clr_i && !(src_i && !smp_q)) |=> !sta_q);
  // R5: level status mirrors the sampled input
  a_r5_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q == TRIG_LEVEL || trig_q == TRIG_LEVEL_ALT) |=> (sta_q == $past(src_i)));

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N = 64
) (
  input  logic [N-1:0]         pend_i,
  input  logic [$clog2(N)-1:0] base_i,
  output logic                 vld_o,
  output logic [$clog2(N)-1:0] id_o
);

  localparam int IW = $clog2(N);
  localparam logic [IW:0] N_V = (IW+1)'(N);

  logic [2*N-1:0] dbl;
  logic [N-1:0]   rot;
  logic [IW-1:0]  off;
  logic [IW:0]    sum;

  always_comb begin
    dbl = {pend_i, pend_i} >> base_i;
    rot = dbl[N-1:0];
    off = '0;
    for (int k = N-1; k >= 0; k--) begin
      if (rot[k]) off = IW'(k);
    end
    sum = {1'b0, base_i} + {1'b0, off};
    if (sum >= N_V) sum = sum - N_V;
    vld_o = |rot;
    id_o  = vld_o ? sum[IW-1:0] : '0;
  end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [7:0]         bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  input  logic [3:0]         bus_be_i,
  output logic [31:0]        bus_rdata_o,
  output logic               irq_o
);

  localparam int IW   = $clog2(NUM_SRC);
  localparam int MAXS = 64;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic cfg_sel, cfg_wr, cur_read;
  assign cfg_sel  = (bus_addr_i[7:6] == 2'b01) && (bus_addr_i[1:0] == 2'b00);
  assign cfg_wr   = bus_wr_i && cfg_sel;
  assign cur_read = bus_rd_i && (bus_addr_i == A_CUR);

  logic [MAXS-1:0] sta_all, pend_all;
  logic [7:0]      cfg_rb [MAXS];

  for (genvar n = 0; n < MAXS; n++) begin : g_src
    if (n < NUM_SRC) begin : g_live
      localparam int         LANE = n % 4;
      localparam logic [3:0] WRD  = 4'(n / 4);
      localparam logic [7:0] SADR = (n < 32) ? A_STAT_LO : A_STAT_HI;
      localparam int         SB   = n % 32;
      logic       we, clr, en;
      logic [1:0] trig;
      assign we  = cfg_wr && (bus_addr_i[5:2] == WRD) && bus_be_i[LANE];
      assign clr = bus_wr_i && (bus_addr_i == SADR) && bus_be_i[SB/8] && bus_wdata_i[SB];
      irqc_src_cell u_cell (
        .clk        (clk),
        .rst_n      (rst_sync_n),
        .src_i      (src_i[n]),
        .cfg_we_i   (we),
        .cfg_en_i   (bus_wdata_i[8*LANE+CFG_EN_BIT]),
        .cfg_trig_i (bus_wdata_i[8*LANE+CFG_TRIG_LSB +: 2]),
        .clr_i      (clr),
        .en_o       (en),
        .trig_o     (trig),
        .sta_o      (sta_all[n]),
        .pend_o     (pend_all[n])
      );
      assign cfg_rb[n] = {2'b00, trig, en, 3'b000};
    end else begin : g_none
      assign sta_all[n]  = 1'b0;
      assign pend_all[n] = 1'b0;
      assign cfg_rb[n]   = 8'h00;
    end
  end

  // global control and rotation pointer
  logic          rot_q, rot_d;
  logic [IW-1:0] ptr_q, ptr_d, base;
  logic          cur_vld;
  logic [IW-1:0] cur_id;

  assign base = rot_q ? ptr_q : '0;

  irqc_prio #(.N(NUM_SRC)) u_prio (
    .pend_i (pend_all[NUM_SRC-1:0]),
    .base_i (base),
    .vld_o  (cur_vld),
    .id_o   (cur_id)
  );

  always_comb begin
    rot_d = rot_q;
    if (bus_wr_i && (bus_addr_i == A_GCTL) && bus_be_i[0])
      rot_d = bus_wdata_i[GCTL_ROT_BIT];
    ptr_d = ptr_q;
    if (cur_read && cur_vld && rot_q)
      ptr_d = (cur_id == IW'(NUM_SRC-1)) ? '0 : cur_id + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rot_q <= 1'b0;
      ptr_q <= '0;
    end else begin
      rot_q <= rot_d;
      ptr_q <= ptr_d;
    end
  end

  assign irq_o = |pend_all;

  // read path
  always_comb begin
    bus_rdata_o = '0;
    if (cfg_sel) begin
      bus_rdata_o = {cfg_rb[{bus_addr_i[5:2], 2'd3}], cfg_rb[{bus_addr_i[5:2], 2'd2}],
                     cfg_rb[{bus_addr_i[5:2], 2'd1}], cfg_rb[{bus_addr_i[5:2], 2'd0}]};
    end else begin
      case (bus_addr_i)
        A_GCTL:    bus_rdata_o[GCTL_ROT_BIT] = rot_q;
        A_STAT_LO: bus_rdata_o = sta_all[31:0];
        A_STAT_HI: bus_rdata_o = sta_all[63:32];
        A_CUR: begin
          bus_rdata_o[CUR_VLD_BIT] = cur_vld;
          bus_rdata_o[IW-1:0]      = cur_id;
        end
        default: ;
      endcase
    end
  end

  logic [NUM_SRC-1:0] below_mask;
  assign below_mask = ~({NUM_SRC{1'b1}} << cur_id);

  // R6: merged line agrees with the selector's valid flag
  a_r6_irq_matches_valid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o == cur_vld);
  // R6: the reported source is really pending
  a_r6_cur_is_pending: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cur_vld |-> pend_all[cur_id]);
  // R7: fixed order leaves nothing pending below the winner
  a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rot_q && cur_vld) |-> ((pend_all[NUM_SRC-1:0] & below_mask) == '0));
  // R8: with two or more stable pending sources a report moves the selection on
  a_r8_rotate_moves: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rot_q && cur_read && cur_vld && $countones(pend_all) > 1)
      |=> (pend_all != $past(pend_all) || !rot_q || cur_id != $past(cur_id)));

endmodule

// File: tb/tb_irq_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ctrl;

  logic        clk;
  logic        rst_n;
  logic [63:0] src;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_be;
  logic [31:0] bus_rdata;
  logic        irq;

  int nchk  = 0;
  int nfail = 0;

  irq_ctrl #(.NUM_SRC(64)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src),
    .bus_wr_i    (bus_wr),
    .bus_rd_i    (bus_rd),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_be_i    (bus_be),
    .bus_rdata_o (bus_rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'h0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic int pick(input logic [63:0] p, input int start);
    for (int k = 0; k < 64; k++) begin
      if (p[(start + k) % 64]) return (start + k) % 64;
    end
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog R9 got running exp finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    src = '0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0; bus_be = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk("R9 irq after reset", 32'(irq), 32'd0);
    rd(8'h88, d); chk("R9 current source", d, 32'h0);
    rd(8'h80, d); chk("R9 status lo", d, 32'h0);
    rd(8'h84, d); chk("R9 status hi", d, 32'h0);
    rd(8'h20, d); chk("R9 rotation bit", d, 32'h0);
    for (int w = 0; w < 16; w++) begin
      rd(8'(8'h40 + 4*w), d); chk("R9 config word", d, 32'h0);
    end

    // per-source sweep
    for (int n = 0; n < 64; n++) begin
      int          lane;
      logic [7:0]  ca, sa;
      logic [3:0]  be;
      logic [31:0] sb;
      lane = n % 4;
      ca   = 8'(8'h40 + 4*(n/4));
      sa   = (n < 32) ? 8'h80 : 8'h84;
      be   = 4'(1 << lane);
      sb   = 32'(1) << (n % 32);

      // R1 config layout
      wr(ca, 32'hFF << (8*lane), be);
      rd(ca, d); chk("R1 reserved bits read zero", d, 32'h38 << (8*lane));
      chk("R2 no irq with input low", 32'(irq), 32'd0);
      wr(ca, 32'h08 << (8*lane), be);
      rd(ca, d); chk("R1 enable level readback", d, 32'h08 << (8*lane));

      // R5 level mode
      src[n] = 1'b1; @(negedge clk);
      chk("R2 level irq", 32'(irq), 32'd1);
      rd(sa, d); chk("R5 level status set", d, sb);
      rd(8'h88, d); chk("R6 R7 current source", d, 32'h8000_0000 | 32'(n));
      wr(sa, sb, 4'hF);
      rd(sa, d); chk("R5 level ignores clear", d, sb);
      src[n] = 1'b0; @(negedge clk);
      chk("R2 level irq drops", 32'(irq), 32'd0);
      rd(sa, d); chk("R5 level status follows", d, 32'h0);

      // R3/R4 rising mode
      wr(ca, 32'h18 << (8*lane), be);
      src[n] = 1'b1; @(negedge clk);
      rd(sa, d); chk("R3 rising latched", d, sb);
      chk("R2 rising irq", 32'(irq), 32'd1);
      wr(sa, 32'h0, 4'hF);
      rd(sa, d); chk("R4 zero write keeps", d, sb);
      wr(sa, sb, 4'hF);
      rd(sa, d); chk("R4 one write clears", d, 32'h0);
      chk("R4 irq gone with input held", 32'(irq), 32'd0);
      src[n] = 1'b0; @(negedge clk);
      rd(sa, d); chk("R3 falling ignored in rising mode", d, 32'h0);

      // R3 falling mode
      wr(ca, 32'h28 << (8*lane), be);
      src[n] = 1'b1; @(negedge clk);
      rd(sa, d); chk("R3 rising ignored in falling mode", d, 32'h0);
      src[n] = 1'b0; @(negedge clk);
      rd(sa, d); chk("R3 falling latched", d, sb);
      chk("R2 falling irq", 32'(irq), 32'd1);
      wr(sa, sb, 4'hF);
      chk("R4 falling cleared", 32'(irq), 32'd0);

      // R3/R2 latch while masked
      wr(ca, 32'h10 << (8*lane), be);
      src[n] = 1'b1; @(negedge clk);
      rd(sa, d); chk("R3 edge latched while disabled", d, sb);
      chk("R2 masked source silent", 32'(irq), 32'd0);
      wr(ca, 32'h18 << (8*lane), be);
      chk("R2 irq on enable", 32'(irq), 32'd1);
      wr(sa, sb, 4'hF);
      src[n] = 1'b0; @(negedge clk);
      wr(ca, 32'h0, be);
      rd(sa, d); chk("R4 status empty at end", d, 32'h0);
    end

    // priority: all level-enabled
    for (int w = 0; w < 16; w++) wr(8'(8'h40 + 4*w), 32'h0808_0808, 4'hF);

    // R7 fixed order
    begin
      logic [63:0] pats [4];
      pats[0] = (64'd1 << 5) | (64'd1 << 17) | (64'd1 << 40);
      pats[1] = 64'd1 << 63;
      pats[2] = (64'd1 << 33) | (64'd1 << 62);
      pats[3] = 64'd0;
      for (int p = 0; p < 4; p++) begin
        int id;
        src = pats[p]; @(negedge clk);
        id = pick(pats[p], 0);
        for (int r = 0; r < 2; r++) begin
          rd(8'h88, d);
          chk("R7 lowest pending", d, (id < 0) ? 32'h0 : (32'h8000_0000 | 32'(id)));
        end
        chk("R6 irq vs pattern", 32'(irq), (id < 0) ? 32'd0 : 32'd1);
      end
    end

    // R8 rotation
    wr(8'h20, 32'h40, 4'h1);
    rd(8'h20, d); chk("R8 rotation bit readback", d, 32'h40);
    begin
      int ptr;
      logic [63:0] pat;
      ptr = 0;
      pat = 64'd1 | (64'd1 << 40) | (64'd1 << 63);
      src = pat; @(negedge clk);
      for (int r = 0; r < 5; r++) begin
        int id;
        id = pick(pat, ptr);
        rd(8'h88, d); chk("R8 rotating wrap", d, 32'h8000_0000 | 32'(id));
        ptr = (id + 1) % 64;
      end
      pat = (64'd1 << 5) | (64'd1 << 17) | (64'd1 << 40);
      src = pat; @(negedge clk);
      for (int r = 0; r < 4; r++) begin
        int id;
        id = pick(pat, ptr);
        rd(8'h88, d); chk("R8 rotating sequence", d, 32'h8000_0000 | 32'(id));
        ptr = (id + 1) % 64;
      end
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule